// File: doc/BRIEF.md
# Buffered Up/Down Timer with Command and DMA-Request Logic

This block is a timer/counter with a settable period and a parameterised set of channels. Each channel either compares the counter against a value to shape an output waveform, or captures the counter value when a trigger arrives. The counter runs in one of two modes. In single-slope mode it counts up and wraps. In dual-slope mode it counts up and then back down. The period and the compare values can be written straight into the active registers. They can also be staged in buffer registers, which are copied in at the next update.

A two-bit command with a strobe lets software force an update, restart the current waveform period, or return the whole timer to its power-on state. A reset command is only taken while the timer is stopped. Every flag-raising condition also gives a one-cycle event pulse. The overflow flag and the channel flags double as DMA requests. Each request is retired when the DMA side touches a register that belongs to it, and not by a write to the flag itself.

Registers are reached through a single access port. That port has no back-pressure: an access is taken in the cycle `acc_en` is high, and read data is combinational in that same cycle. All other pins are plain level or strobe signals.

Top module: `ctmr_timer`

## Requirements
- R1: In single-slope mode (`dual_slope`=0), while `run_en` is high the counter rises by one per clock. In the clock where it equals or exceeds the active period, it returns to 0 instead. While `run_en` is low the counter holds its value.
- R2: In dual-slope mode the counter counts up until it reaches the period and then turns down (`cnt_down`=1), taking the step period-1. On reaching 0 while counting down, it turns up and steps to 1.
- R3: Each wrap or reversal of the counter sets flag bit 0. In the same clock edge it raises `ev_ovf` for exactly one cycle.
- R4: A channel in compare mode (`cap_mode[i]`=0) whose value equals the counter while running sets flag bit 2+i and pulses `ev_cc[i]`. On that match its output goes to 0 in single-slope mode. In dual-slope mode it goes to 0 when counting up and to 1 when counting down. In single-slope mode a wrap without a match drives the output to 1.
- R5: In capture mode a `cap_trig[i]` pulse that finds the channel buffer empty stores the counter in the buffer, marks it full, sets flag bit 2+i and pulses `ev_cc[i]`. A trigger that finds the buffer full keeps the stored value, sets flag bit 1 and pulses `ev_err`. Any read of the channel's active or buffer address empties the buffer.
- R6: At each wrap or reversal, unless `lock_upd` is high, a full period buffer and the full buffers of compare channels are copied into the active registers, and those buffers are marked empty.
- R7: Command code 1 (update) has the same effect as R6. It is ignored while `lock_upd` is high.
- R8: Command code 2 (restart) sets the counter to 0, the direction to up and every compare output to 0 at the next edge. It overrides counting, and it is taken whether the timer is running or stopped.
- R9: Out of reset, and after command code 3 while `run_en` is low, the values are: counter 0, period all ones, buffers 0 and empty, channel values 0, outputs 0 and flags 0. Command code 3 while running is ignored.
- R10: Flag bits are cleared by writing 1 to `flag_clr` at the matching position (bit 0 overflow, bit 1 error, bit 2+i channel i). A set and a clear in the same cycle leave the flag set.
- R11: `dma_req_ovf` follows flag bit 0, and a DMA write (`acc_dma`=1) to the counter, period or period-buffer address clears it. `dma_req_cc[i]` follows flag bit 2+i, and a DMA read or write of that channel's active or buffer address clears it. The error flag raises no request and is not cleared by DMA accesses. Accesses with `acc_dma`=0 clear no flag.
- R12: Access addresses are 0 counter, 1 period, 2 period buffer, 4+2i channel i active value, and 5+2i channel i buffer. A buffer write marks the buffer full. Command code 0 does nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run_en | input | 1 | Timer running (low means stopped) |
| dual_slope | input | 1 | 1 selects up/down counting |
| lock_upd | input | 1 | Blocks natural and commanded updates |
| cap_mode | input | NUM_CH | Per-channel capture (1) or compare (0) |
| cap_trig | input | NUM_CH | Per-channel capture trigger strobe |
| cmd_stb | input | 1 | Command strobe |
| cmd_code | input | 2 | 0 none, 1 update, 2 restart, 3 reset |
| acc_en | input | 1 | Register access valid this cycle |
| acc_we | input | 1 | 1 write, 0 read |
| acc_dma | input | 1 | Access comes from the DMA side |
| acc_addr | input | AW | Register address |
| acc_wdata | input | CW | Write data |
| acc_rdata | output | CW | Read data for the current address |
| flag_clr | input | NUM_CH+2 | Write-one-to-clear for flags |
| cnt_q | output | CW | Counter value |
| cnt_down | output | 1 | Current direction (1 down) |
| per_q | output | CW | Active period |
| per_buf_q | output | CW | Period buffer |
| per_buf_vld | output | 1 | Period buffer full |
| cc_q | output | NUM_CH*CW | Channel active values, channel 0 lowest |
| cc_buf_q | output | NUM_CH*CW | Channel buffers |
| cc_buf_vld | output | NUM_CH | Channel buffer full |
| cmp_out | output | NUM_CH | Compare waveform outputs |
| irq_flags | output | NUM_CH+2 | Interrupt flags |
| ev_ovf | output | 1 | Wrap/reversal event pulse |
| ev_err | output | 1 | Capture error event pulse |
| ev_cc | output | NUM_CH | Channel event pulses |
| dma_req_ovf | output | 1 | Overflow DMA request |
| dma_req_cc | output | NUM_CH | Channel DMA requests |

## Verification
Two pairs of functions can land on the same edge. In the first pair, a flag's hardware set meets its software clear. The bench preloads the counter with the period while stopped. It then starts the timer in the very cycle that it writes 1 to the overflow clear bit, and the flag must read 1 afterwards. In the second pair, a restart meets normal counting: the restart is issued while the timer runs, and the counter must read 0 rather than its next count value. A reset command given while running is also checked, and the period and error flag must be left intact.

// File: rtl/ctmr_pkg.sv
package ctmr_pkg;
  typedef enum logic [1:0] {
    CMD_NONE    = 2'd0,
    CMD_UPDATE  = 2'd1,
    CMD_RESTART = 2'd2,
    CMD_RESET   = 2'd3
  } ctmr_cmd_e;

  // flag vector positions
  localparam int unsigned FLG_OVF = 0;
  localparam int unsigned FLG_ERR = 1;
  localparam int unsigned FLG_CH0 = 2;

  // access port address map
  localparam int unsigned ADR_CNT    = 0;
  localparam int unsigned ADR_PER    = 1;
  localparam int unsigned ADR_PERBUF = 2;
  localparam int unsigned ADR_CH0    = 4;
endpackage

// File: rtl/ctmr_counter.sv
module ctmr_counter #(
  parameter int unsigned CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          dual,
  input  logic          restart,
  input  logic          clear_all,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  input  logic [CW-1:0] per,
  output logic [CW-1:0] cnt,
  output logic          down,
  output logic          edge_hit
);
  localparam logic [CW-1:0] ONE = {{(CW-1){1'b0}}, 1'b1};

  logic at_top, at_bot, held;

  always_comb begin
    at_top   = (cnt >= per);
    at_bot   = (cnt == '0);
    held     = restart | clear_all | load;
    edge_hit = 1'b0;
    if (run && !held) begin
      if (dual) edge_hit = down ? at_bot : at_top;
      else      edge_hit = at_top;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt  <= '0;
      down <= 1'b0;
    end else if (clear_all || restart) begin
      cnt  <= '0;
      down <= 1'b0;
    end else if (load) begin
      cnt <= load_val;
    end else if (run) begin
      if (!dual) begin
        down <= 1'b0;
        cnt  <= at_top ? '0 : cnt + ONE;
      end else if (down) begin
        if (at_bot) begin
          down <= 1'b0;
          cnt  <= cnt + ONE;
        end else begin
          cnt <= cnt - ONE;
        end
      end else begin
        if (at_top) begin
          down <= 1'b1;
          cnt  <= cnt - ONE;
        end else begin
          cnt <= cnt + ONE;
        end
      end
    end
  end
endmodule

// File: rtl/ctmr_channel.sv
module ctmr_channel #(
  parameter int unsigned CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear_all,
  input  logic          restart,
  input  logic          run,
  input  logic          dual,
  input  logic          down,
  input  logic          wrap,
  input  logic          upd,
  input  logic          cap_mode,
  input  logic          cap_trig,
  input  logic [CW-1:0] cnt,
  input  logic          cc_we,
  input  logic          buf_we,
  input  logic          rd_ack,
  input  logic [CW-1:0] wdata,
  output logic [CW-1:0] cc,
  output logic [CW-1:0] buf_q,
  output logic          vld,
  output logic          out,
  output logic          hit,
  output logic          cap_err
);
  logic match, cap_ok, take;

  always_comb begin
    match   = run && !cap_mode && !restart && !clear_all && (cnt == cc);
    cap_ok  = cap_trig && cap_mode && !vld && !clear_all;
    cap_err = cap_trig && cap_mode && vld && !clear_all;
    hit     = match | cap_ok;
    take    = upd && !cap_mode && vld;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clear_all) begin
      cc    <= '0;
      buf_q <= '0;
      vld   <= 1'b0;
    end else begin
      if (cc_we)     cc <= wdata;
      else if (take) cc <= buf_q;

      if (buf_we) begin
        buf_q <= wdata;
        vld   <= 1'b1;
      end else if (cap_ok) begin
        buf_q <= cnt;
        vld   <= 1'b1;
      end else if (rd_ack && cap_mode) begin
        vld <= 1'b0;
      end else if (take) begin
        vld <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clear_all || restart) out <= 1'b0;
    else if (match)                     out <= dual ? down : 1'b0;
    else if (wrap && !dual && !cap_mode) out <= 1'b1;
  end
endmodule

// File: rtl/ctmr_flags.sv
module ctmr_flags #(
  parameter int unsigned NF = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear_all,
  input  logic [NF-1:0] set,
  input  logic [NF-1:0] clr,
  output logic [NF-1:0] flags,
  output logic [NF-1:0] events
);
  always_ff @(posedge clk) begin
    if (!rst_n || clear_all) begin
      flags  <= '0;
      events <= '0;
    end else begin
      flags  <= (flags & ~clr) | set;
      events <= set;
    end
  end
endmodule

// File: rtl/ctmr_timer.sv
module ctmr_timer
  import ctmr_pkg::*;
#(
  parameter int unsigned CW     = 16,
  parameter int unsigned NUM_CH = 2,
  localparam int unsigned NF    = NUM_CH + 2,
  localparam int unsigned NADR  = ADR_CH0 + 2 * NUM_CH,
  localparam int unsigned AW    = $clog2(NADR)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 run_en,
  input  logic                 dual_slope,
  input  logic                 lock_upd,
  input  logic [NUM_CH-1:0]    cap_mode,
  input  logic [NUM_CH-1:0]    cap_trig,
  input  logic                 cmd_stb,
  input  logic [1:0]           cmd_code,
  input  logic                 acc_en,
  input  logic                 acc_we,
  input  logic                 acc_dma,
  input  logic [AW-1:0]        acc_addr,
  input  logic [CW-1:0]        acc_wdata,
  output logic [CW-1:0]        acc_rdata,
  input  logic [NF-1:0]        flag_clr,
  output logic [CW-1:0]        cnt_q,
  output logic                 cnt_down,
  output logic [CW-1:0]        per_q,
  output logic [CW-1:0]        per_buf_q,
  output logic                 per_buf_vld,
  output logic [NUM_CH*CW-1:0] cc_q,
  output logic [NUM_CH*CW-1:0] cc_buf_q,
  output logic [NUM_CH-1:0]    cc_buf_vld,
  output logic [NUM_CH-1:0]    cmp_out,
  output logic [NF-1:0]        irq_flags,
  output logic                 ev_ovf,
  output logic                 ev_err,
  output logic [NUM_CH-1:0]    ev_cc,
  output logic                 dma_req_ovf,
  output logic [NUM_CH-1:0]    dma_req_cc
);
  localparam logic [CW-1:0] PER_INIT = '1;

  ctmr_cmd_e cmd;
  logic      do_reset, do_restart, do_update;
  logic      wr_cnt, wr_per, wr_pbuf, dma_ovf_ack;
  logic      wrap;

  logic [CW-1:0]     cc_arr  [NUM_CH];
  logic [CW-1:0]     buf_arr [NUM_CH];
  logic [NUM_CH-1:0] ch_hit, ch_err, ch_dma_ack;
  logic [NF-1:0]     flg_set, flg_clr, flg_evt;

  // command decode
  always_comb begin
    cmd        = ctmr_cmd_e'(cmd_code);
    do_reset   = cmd_stb && (cmd == CMD_RESET) && !run_en;
    do_restart = cmd_stb && (cmd == CMD_RESTART);
    do_update  = !lock_upd && ((cmd_stb && (cmd == CMD_UPDATE)) || wrap);
  end

  // access decode for the timer-wide registers
  always_comb begin
    wr_cnt      = acc_en && acc_we && (acc_addr == AW'(ADR_CNT));
    wr_per      = acc_en && acc_we && (acc_addr == AW'(ADR_PER));
    wr_pbuf     = acc_en && acc_we && (acc_addr == AW'(ADR_PERBUF));
    dma_ovf_ack = acc_dma && (wr_cnt || wr_per || wr_pbuf);
  end

  ctmr_counter #(.CW(CW)) u_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (run_en),
    .dual      (dual_slope),
    .restart   (do_restart),
    .clear_all (do_reset),
    .load      (wr_cnt),
    .load_val  (acc_wdata),
    .per       (per_q),
    .cnt       (cnt_q),
    .down      (cnt_down),
    .edge_hit  (wrap)
  );

  // period and its buffer
  always_ff @(posedge clk) begin
    if (!rst_n || do_reset) begin
      per_q       <= PER_INIT;
      per_buf_q   <= '0;
      per_buf_vld <= 1'b0;
    end else begin
      if (wr_per)                        per_q <= acc_wdata;
      else if (do_update && per_buf_vld) per_q <= per_buf_q;

      if (wr_pbuf) begin
        per_buf_q   <= acc_wdata;
        per_buf_vld <= 1'b1;
      end else if (do_update) begin
        per_buf_vld <= 1'b0;
      end
    end
  end

  // channels
  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    localparam int unsigned ADR_A = ADR_CH0 + 2 * i;
    localparam int unsigned ADR_B = ADR_A + 1;
    logic sel_a, sel_b;

    always_comb begin
      sel_a         = acc_en && (acc_addr == AW'(ADR_A));
      sel_b         = acc_en && (acc_addr == AW'(ADR_B));
      ch_dma_ack[i] = acc_dma && (sel_a || sel_b);
    end

    ctmr_channel #(.CW(CW)) u_ch (
      .clk       (clk),
      .rst_n     (rst_n),
      .clear_all (do_reset),
      .restart   (do_restart),
      .run       (run_en),
      .dual      (dual_slope),
      .down      (cnt_down),
      .wrap      (wrap),
      .upd       (do_update),
      .cap_mode  (cap_mode[i]),
      .cap_trig  (cap_trig[i]),
      .cnt       (cnt_q),
      .cc_we     (sel_a && acc_we),
      .buf_we    (sel_b && acc_we),
      .rd_ack    ((sel_a || sel_b) && !acc_we),
      .wdata     (acc_wdata),
      .cc        (cc_arr[i]),
      .buf_q     (buf_arr[i]),
      .vld       (cc_buf_vld[i]),
      .out       (cmp_out[i]),
      .hit       (ch_hit[i]),
      .cap_err   (ch_err[i])
    );

    assign cc_q[i*CW +: CW]     = cc_arr[i];
    assign cc_buf_q[i*CW +: CW] = buf_arr[i];
  end

  // flags, events and DMA requests
  always_comb begin
    flg_set                       = '0;
    flg_set[FLG_OVF]              = wrap;
    flg_set[FLG_ERR]              = |ch_err;
    flg_set[FLG_CH0 +: NUM_CH]    = ch_hit;
    flg_clr                       = flag_clr;
    flg_clr[FLG_OVF]              = flag_clr[FLG_OVF] | dma_ovf_ack;
    flg_clr[FLG_CH0 +: NUM_CH]    = flag_clr[FLG_CH0 +: NUM_CH] | ch_dma_ack;
  end

  ctmr_flags #(.NF(NF)) u_flg (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear_all (do_reset),
    .set       (flg_set),
    .clr       (flg_clr),
    .flags     (irq_flags),
    .events    (flg_evt)
  );

  assign ev_ovf      = flg_evt[FLG_OVF];
  assign ev_err      = flg_evt[FLG_ERR];
  assign ev_cc       = flg_evt[FLG_CH0 +: NUM_CH];
  assign dma_req_ovf = irq_flags[FLG_OVF];
  assign dma_req_cc  = irq_flags[FLG_CH0 +: NUM_CH];

  // read mux
  always_comb begin
    acc_rdata = '0;
    if (acc_addr == AW'(ADR_CNT))    acc_rdata = cnt_q;
    if (acc_addr == AW'(ADR_PER))    acc_rdata = per_q;
    if (acc_addr == AW'(ADR_PERBUF)) acc_rdata = per_buf_q;
    for (int k = 0; k < NUM_CH; k++) begin
      if (acc_addr == AW'(ADR_CH0 + 2 * k))     acc_rdata = cc_arr[k];
      if (acc_addr == AW'(ADR_CH0 + 2 * k + 1)) acc_rdata = buf_arr[k];
    end
  end
endmodule

// File: rtl/ctmr_timer_chk.sv
module ctmr_timer_chk #(
  parameter int unsigned CW     = 16,
  parameter int unsigned NUM_CH = 2,
  localparam int unsigned NF    = NUM_CH + 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              run_en,
  input logic              dual_slope,
  input logic              lock_upd,
  input logic              cmd_stb,
  input logic [1:0]        cmd_code,
  input logic              acc_en,
  input logic              acc_we,
  input logic [CW-1:0]     cnt_q,
  input logic              cnt_down,
  input logic [CW-1:0]     per_q,
  input logic [NUM_CH-1:0] cmp_out,
  input logic [NF-1:0]     irq_flags,
  input logic              ev_ovf,
  input logic              ev_err,
  input logic [NUM_CH-1:0] ev_cc
);
  a_r3_event_has_flag: assert property (@(posedge clk) disable iff (!rst_n)
    ev_ovf |-> irq_flags[0]);

  a_r5_err_event_has_flag: assert property (@(posedge clk) disable iff (!rst_n)
    ev_err |-> irq_flags[1]);

  a_r4_cc_event_has_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_cc & ~irq_flags[NF-1:2]) == '0);

  a_r1_wrap_lands_on_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_ovf && !dual_slope && !$past(dual_slope) && !$past(acc_en && acc_we))
      |-> (cnt_q == '0));

  a_r8_restart_zeroes: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_stb && cmd_code == 2'd2)
      |=> (cnt_q == '0) && !cnt_down && (cmp_out == '0));

  a_r9_reset_when_stopped: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_stb && cmd_code == 2'd3 && !run_en)
      |=> (cnt_q == '0) && (per_q == '1) && (irq_flags == '0));

  a_r7_lock_holds_period: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_upd && !(acc_en && acc_we) && !(cmd_stb && cmd_code == 2'd3))
      |=> $stable(per_q));
endmodule

bind ctmr_timer ctmr_timer_chk #(.CW(CW), .NUM_CH(NUM_CH)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .run_en     (run_en),
  .dual_slope (dual_slope),
  .lock_upd   (lock_upd),
  .cmd_stb    (cmd_stb),
  .cmd_code   (cmd_code),
  .acc_en     (acc_en),
  .acc_we     (acc_we),
  .cnt_q      (cnt_q),
  .cnt_down   (cnt_down),
  .per_q      (per_q),
  .cmp_out    (cmp_out),
  .irq_flags  (irq_flags),
  .ev_ovf     (ev_ovf),
  .ev_err     (ev_err),
  .ev_cc      (ev_cc)
);

// File: tb/test_ctmr_timer.sv
module test_ctmr_timer;
  localparam int unsigned CW = 16;
  localparam int unsigned NC = 2;
  localparam int unsigned NF = NC + 2;
  localparam int unsigned AW = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic run_en = 0, dual_slope = 0, lock_upd = 0;
  logic [NC-1:0] cap_mode = 2'b10, cap_trig = '0;
  logic cmd_stb = 0;
  logic [1:0] cmd_code = 0;
  logic acc_en = 0, acc_we = 0, acc_dma = 0;
  logic [AW-1:0] acc_addr = '0;
  logic [CW-1:0] acc_wdata = '0, acc_rdata;
  logic [NF-1:0] flag_clr = '0;
  logic [CW-1:0] cnt_q, per_q, per_buf_q;
  logic cnt_down, per_buf_vld, ev_ovf, ev_err, dma_req_ovf;
  logic [NC*CW-1:0] cc_q, cc_buf_q;
  logic [NC-1:0] cc_buf_vld, cmp_out, ev_cc, dma_req_cc;
  logic [NF-1:0] irq_flags;

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  ctmr_timer #(.CW(CW), .NUM_CH(NC)) i_ctmr_timer (
    .clk(clk), .rst_n(rst_n), .run_en(run_en), .dual_slope(dual_slope),
    .lock_upd(lock_upd), .cap_mode(cap_mode), .cap_trig(cap_trig),
    .cmd_stb(cmd_stb), .cmd_code(cmd_code), .acc_en(acc_en), .acc_we(acc_we),
    .acc_dma(acc_dma), .acc_addr(acc_addr), .acc_wdata(acc_wdata),
    .acc_rdata(acc_rdata), .flag_clr(flag_clr), .cnt_q(cnt_q),
    .cnt_down(cnt_down), .per_q(per_q), .per_buf_q(per_buf_q),
    .per_buf_vld(per_buf_vld), .cc_q(cc_q), .cc_buf_q(cc_buf_q),
    .cc_buf_vld(cc_buf_vld), .cmp_out(cmp_out), .irq_flags(irq_flags),
    .ev_ovf(ev_ovf), .ev_err(ev_err), .ev_cc(ev_cc),
    .dma_req_ovf(dma_req_ovf), .dma_req_cc(dma_req_cc)
  );

  task automatic tick(int n = 1);
    for (int k = 0; k < n; k++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic acc(logic we, logic dma, int addr, int data);
    acc_en = 1; acc_we = we; acc_dma = dma;
    acc_addr = AW'(addr); acc_wdata = CW'(data);
    tick();
    acc_en = 0; acc_we = 0; acc_dma = 0;
  endtask

  task automatic command(int code);
    cmd_stb = 1; cmd_code = 2'(code);
    tick();
    cmd_stb = 0; cmd_code = 0;
  endtask

  task automatic clear_flags(int mask);
    flag_clr = NF'(mask);
    tick();
    flag_clr = '0;
  endtask

  task automatic t_reset_state;
    check("R9 cnt", cnt_q, 0);
    check("R9 per", per_q, 16'hFFFF);
    check("R9 flags", irq_flags, 0);
    check("R9 outs", cmp_out, 0);
    check("R9 pbuf vld", per_buf_vld, 0);
  endtask

  task automatic t_single;
    acc(1, 0, 1, 5);
    run_en = 1;
    tick(5);
    check("R1 count", cnt_q, 5);
    tick();
    check("R1 wrap", cnt_q, 0);
    check("R3 ev_ovf", ev_ovf, 1);
    check("R3 flag", irq_flags[0], 1);
    tick();
    check("R3 pulse ends", ev_ovf, 0);
    check("R1 count after wrap", cnt_q, 1);
    run_en = 0;
    tick(3);
    check("R1 hold when stopped", cnt_q, 1);
  endtask

  task automatic t_w1c;
    clear_flags(4'b0001);
    check("R10 w1c one bit", irq_flags, 4'b0100);
    clear_flags(4'b0100);
    check("R10 w1c other bit", irq_flags, 0);
    acc(1, 0, 0, 5);
    run_en = 1; flag_clr = 4'b0001;
    tick();
    run_en = 0; flag_clr = '0;
    check("R10 set wins", irq_flags[0], 1);
    check("R1 wrap at period", cnt_q, 0);
    clear_flags(4'hF);
  endtask

  task automatic t_compare;
    command(2);
    acc(1, 0, 4, 3);
    run_en = 1;
    tick(3);
    check("R4 no early match", irq_flags[2], 0);
    tick();
    check("R4 match flag", irq_flags[2], 1);
    check("R4 match event", ev_cc[0], 1);
    tick();
    check("R4 event one cycle", ev_cc[0], 0);
    tick();
    check("R4 wrap sets out", cmp_out[0], 1);
    tick(3);
    check("R4 out holds", cmp_out[0], 1);
    tick();
    check("R4 match clears out", cmp_out[0], 0);
    run_en = 0;
  endtask

  task automatic t_dma;
    check("R11 start flags", irq_flags, 4'b0101);
    acc(1, 0, 1, 5);
    check("R11 sw write no clear", dma_req_ovf, 1);
    acc(0, 0, 4, 0);
    check("R11 sw read no clear", dma_req_cc[0], 1);
    acc(0, 1, 5, 0);
    check("R11 dma read buf acks ch", dma_req_cc[0], 0);
    check("R11 ovf untouched", dma_req_ovf, 1);
    acc(1, 1, 2, 8);
    check("R11 dma write pbuf acks ovf", dma_req_ovf, 0);
    check("R12 pbuf full", per_buf_vld, 1);
    check("R12 per unchanged", per_q, 5);
  endtask

  task automatic t_update;
    lock_upd = 1;
    command(1);
    check("R7 locked keeps per", per_q, 5);
    check("R7 locked keeps vld", per_buf_vld, 1);
    lock_upd = 0;
    command(1);
    check("R7 update copies", per_q, 8);
    check("R7 update empties", per_buf_vld, 0);
    acc(1, 0, 2, 4);
    acc(1, 0, 5, 2);
    command(2);
    run_en = 1;
    tick(8);
    check("R6 before wrap", per_q, 8);
    tick();
    check("R6 per copied", per_q, 4);
    check("R6 pbuf emptied", per_buf_vld, 0);
    check("R6 cc copied", cc_q[CW-1:0], 2);
    check("R6 ccbuf emptied", cc_buf_vld[0], 0);
    run_en = 0;
  endtask

  task automatic t_restart;
    check("R8 out high before", cmp_out[0], 1);
    run_en = 1;
    tick();
    check("R8 counting", cnt_q, 1);
    command(2);
    check("R8 counter zero", cnt_q, 0);
    check("R8 outs zero", cmp_out, 0);
    check("R8 dir up", cnt_down, 0);
    tick();
    check("R8 resumes", cnt_q, 1);
    run_en = 0;
  endtask

  task automatic t_dual;
    clear_flags(4'hF);
    command(2);
    acc(1, 0, 1, 3);
    dual_slope = 1; run_en = 1;
    tick(3);
    check("R2 up to top", cnt_q, 3);
    check("R4 up match low", cmp_out[0], 0);
    tick();
    check("R2 turn down", cnt_q, 2);
    check("R2 dir down", cnt_down, 1);
    check("R3 top event", ev_ovf, 1);
    tick();
    check("R4 down match high", cmp_out[0], 1);
    tick();
    check("R2 bottom", cnt_q, 0);
    tick();
    check("R2 turn up", cnt_q, 1);
    check("R2 dir up", cnt_down, 0);
    check("R3 bottom event", ev_ovf, 1);
    run_en = 0; dual_slope = 0;
  endtask

  task automatic t_capture;
    clear_flags(4'hF);
    acc(1, 0, 0, 7);
    cap_trig = 2'b10; tick(); cap_trig = '0;
    check("R5 stored", cc_buf_q[2*CW-1:CW], 7);
    check("R5 full", cc_buf_vld[1], 1);
    check("R5 flag", irq_flags[3], 1);
    check("R5 event", ev_cc[1], 1);
    acc(1, 0, 0, 9);
    cap_trig = 2'b10; tick(); cap_trig = '0;
    check("R5 err flag", irq_flags[1], 1);
    check("R5 err event", ev_err, 1);
    check("R5 kept", cc_buf_q[2*CW-1:CW], 7);
    check("R11 err no request", {dma_req_ovf, dma_req_cc}, 3'b010);
    acc_en = 1; acc_we = 0; acc_dma = 1; acc_addr = 3'd7;
    #1;
    check("R12 read buffer", acc_rdata, 7);
    tick();
    acc_en = 0; acc_dma = 0;
    check("R11 dma read acks ch1", irq_flags[3], 0);
    check("R11 err kept", irq_flags[1], 1);
    check("R5 read empties", cc_buf_vld[1], 0);
    cap_trig = 2'b10; tick(); cap_trig = '0;
    check("R5 new capture", cc_buf_q[2*CW-1:CW], 9);
  endtask

  task automatic t_cmd_reset;
    command(0);
    check("R12 none keeps cnt", cnt_q, 9);
    check("R12 none keeps per", per_q, 3);
    run_en = 1;
    command(3);
    check("R9 running keeps per", per_q, 3);
    check("R9 running keeps err", irq_flags[1], 1);
    run_en = 0;
    command(3);
    check("R9 per restored", per_q, 16'hFFFF);
    check("R9 flags cleared", irq_flags, 0);
    check("R9 cnt cleared", cnt_q, 0);
    check("R9 buffers cleared", {cc_buf_vld, cc_buf_q}, 0);
    check("R9 cc cleared", cc_q, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    tick();
    t_reset_state();
    t_single();
    t_w1c();
    t_compare();
    t_dma();
    t_update();
    t_restart();
    t_dual();
    t_capture();
    t_cmd_reset();
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule